// File: doc/BRIEF.md
# Self-Timed Page Operation Sequencer

This block carries out the slow internal page operations of a page-organised
non-volatile store once a serial command has been framed and chip select has
gone high. A decoder elsewhere turns the command into a one-cycle start
request, an operation code and a page number. The sequencer then works on its
own page memory (`N_PAGES` pages of `PAGE_BYTES` bytes) and on the single
page-sized working buffer that the host fills and reads between operations.

Four operations are supported. Two of them are compound. Program erases the
page to all ones and then writes the buffer into it. Transfer copies a page
into the buffer. Compare checks every byte of a page against the buffer and
latches whether any byte differs. Rewrite first transfers a page into the
buffer and then erases and programs that same page from the buffer. Each
phase lasts a fixed number of clock cycles set by a parameter: `T_ERASE`,
`T_PROG`, or `T_XFR` for transfer and compare. This models the self-timed
worst-case durations. The status byte shows a ready flag and the last compare
result. A done pulse marks the return to idle.

Top module: `page_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of an operation, `status_o` reads 8'h80 (ready set, compare flag clear, bits 5..0 zero) and `done_o` is low.
- R2: From the clock edge that accepts a start until the operation ends, status bit 7 reads 0. The operation lasts exactly the sum of its phase lengths, in cycles: program `T_ERASE+T_PROG`, transfer `T_XFR`, compare `T_XFR`, rewrite `T_XFR+T_ERASE+T_PROG`.
- R3: `done_o` is high for exactly one cycle, in the first cycle in which status bit 7 is back at 1.
- R4: Op code 0 (program) leaves the selected page equal to the buffer contents that were present at start. It leaves the buffer and every other page unchanged.
- R5: Op code 1 (transfer) leaves the buffer equal to the selected page. The page memory is unchanged.
- R6: Op code 2 (compare) sets status bit 6 to 1 if any of the `PAGE_BYTES` byte pairs differs, including a lone difference in the first or last byte, and to 0 if all bytes match. Buffer and pages are unchanged.
- R7: Op code 3 (rewrite) leaves the buffer equal to the selected page. The page keeps its contents.
- R8: A start request that arrives while an operation runs is ignored. It changes neither the running operation's duration nor its result.
- R9: Status bit 6 changes only at the end of a compare. Program, transfer and rewrite leave it as it was.
- R10: Host buffer writes that arrive while an operation runs are ignored.
- R11: While idle, host reads of the buffer (`hbuf_addr_i`) and of the page memory (`hmem_page_i`, `hmem_byte_i`) return data one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request (chip-select rise event) |
| op_i | input | 2 | 0 program, 1 transfer, 2 compare, 3 rewrite |
| page_i | input | 3 | Page the operation works on |
| hbuf_we_i | input | 1 | Host buffer write strobe (idle only) |
| hbuf_addr_i | input | 9 | Host buffer byte address for write and read |
| hbuf_wdata_i | input | 8 | Host buffer write data |
| hbuf_rdata_o | output | 8 | Host buffer read data, one cycle after address |
| hmem_page_i | input | 3 | Host page-memory read: page |
| hmem_byte_i | input | 9 | Host page-memory read: byte in page |
| hmem_rdata_o | output | 8 | Host page-memory read data, one cycle after address |
| status_o | output | 8 | Bit 7 ready, bit 6 compare mismatch, others 0 |
| done_o | output | 1 | One-cycle pulse on return to idle |

## Verification
The only result whose timing the bench must predict is the done pulse. If the start edge is cycle 0, done is due in the cycle numbered by the sum of the phase lengths. The bench drives start on a falling edge, counts rising edges from the accepting edge, and samples done and ready on each following falling edge, so the count equals the expected duration exactly. Memory and buffer contents are only read while idle. Each host read is given one rising edge before it is sampled at the next falling edge. The checks that an injected start or buffer write was ignored are made after done, by reading back the buffer and the page.

// File: rtl/page_seq_pkg.sv
package page_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_XFER = 2'd1,
    OP_COMP = 2'd2,
    OP_REWR = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PH_ERASE = 2'd0,
    PH_PROG  = 2'd1,
    PH_XFER  = 2'd2,
    PH_COMP  = 2'd3
  } phase_e;

  localparam int STAT_READY = 7;
  localparam int STAT_MISM  = 6;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/page_ram.sv
module page_ram #(
  parameter int DEPTH = 264,
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // One write port and one registered read port, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/page_seq_ctrl.sv
module page_seq_ctrl
  import page_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int N_PAGES    = 8,
  parameter int T_ERASE    = 300,
  parameter int T_PROG     = 320,
  parameter int T_XFR      = 280,
  parameter int PW         = $clog2(N_PAGES),
  parameter int BW         = $clog2(PAGE_BYTES),
  parameter int MW         = $clog2(N_PAGES * PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  op_e           op_i,
  input  logic [PW-1:0] page_i,
  input  logic [7:0]    mem_rdata_i,
  input  logic [7:0]    buf_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mism_o,
  output logic          mem_we_o,
  output logic [MW-1:0] mem_waddr_o,
  output logic [7:0]    mem_wdata_o,
  output logic [MW-1:0] mem_raddr_o,
  output logic          buf_we_o,
  output logic [BW-1:0] buf_waddr_o,
  output logic [7:0]    buf_wdata_o,
  output logic [BW-1:0] buf_raddr_o
);

  localparam int TMAX = (T_ERASE > T_PROG) ? ((T_ERASE > T_XFR) ? T_ERASE : T_XFR)
                                           : ((T_PROG  > T_XFR) ? T_PROG  : T_XFR);
  localparam int CW = $clog2(TMAX) + 1;
  localparam logic [CW-1:0] LAST_E = CW'(T_ERASE - 1);
  localparam logic [CW-1:0] LAST_P = CW'(T_PROG - 1);
  localparam logic [CW-1:0] LAST_X = CW'(T_XFR - 1);
  localparam logic [CW-1:0] NBYTES = CW'(PAGE_BYTES);

  logic          busy_q, done_q, mism_q, acc_q;
  op_e           op_q;
  phase_e        phase_q, phase_first, phase_next;
  logic [CW-1:0] cnt_q, cnt_last;
  logic [PW-1:0] page_q;

  // Read pipeline: address issued in one cycle, data used in the next.
  logic          rd_vld_q;
  logic [BW-1:0] rd_idx_q;
  phase_e        rd_ph_q;

  logic          in_range, phase_end, phase_final, accept, erase_wr, reads_now;
  logic [BW-1:0] byte_idx;
  logic [MW-1:0] page_base;

  assign accept    = start_i && !busy_q;
  assign in_range  = cnt_q < NBYTES;
  assign byte_idx  = cnt_q[BW-1:0];
  assign page_base = MW'(page_q) * MW'(PAGE_BYTES);

  always_comb begin
    case (phase_q)
      PH_ERASE: cnt_last = LAST_E;
      PH_PROG:  cnt_last = LAST_P;
      default:  cnt_last = LAST_X;
    endcase
  end

  // Program ends every compound sequence that writes; transfer and compare
  // finish in a single phase unless they lead a rewrite.
  assign phase_end   = busy_q && (cnt_q == cnt_last);
  assign phase_final = (phase_q == PH_PROG) || (op_q == OP_XFER) || (op_q == OP_COMP);

  always_comb begin
    case (op_i)
      OP_PROG: phase_first = PH_ERASE;
      OP_XFER: phase_first = PH_XFER;
      OP_COMP: phase_first = PH_COMP;
      default: phase_first = PH_XFER;
    endcase
  end

  always_comb begin
    case (phase_q)
      PH_XFER:  phase_next = PH_ERASE;
      default:  phase_next = PH_PROG;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      op_q    <= OP_PROG;
      phase_q <= PH_ERASE;
      cnt_q   <= '0;
      page_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        op_q    <= op_i;
        phase_q <= phase_first;
        cnt_q   <= '0;
        page_q  <= page_i;
      end else if (phase_end) begin
        cnt_q <= '0;
        if (phase_final) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          phase_q <= phase_next;
        end
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign reads_now = busy_q && in_range && (phase_q != PH_ERASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q <= 1'b0;
      rd_idx_q <= '0;
      rd_ph_q  <= PH_ERASE;
    end else begin
      rd_vld_q <= reads_now;
      rd_idx_q <= byte_idx;
      rd_ph_q  <= phase_q;
    end
  end

  // Compare: accumulate any mismatch, publish it when the phase closes.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= 1'b0;
      mism_q <= 1'b0;
    end else begin
      if (accept) acc_q <= 1'b0;
      else if (rd_vld_q && rd_ph_q == PH_COMP && mem_rdata_i != buf_rdata_i) acc_q <= 1'b1;
      if (phase_end && phase_q == PH_COMP) mism_q <= acc_q;
    end
  end

  assign erase_wr    = busy_q && (phase_q == PH_ERASE) && in_range;
  assign mem_we_o    = erase_wr || (rd_vld_q && rd_ph_q == PH_PROG);
  assign mem_waddr_o = erase_wr ? page_base + MW'(byte_idx) : page_base + MW'(rd_idx_q);
  assign mem_wdata_o = erase_wr ? ERASED_BYTE : buf_rdata_i;
  assign mem_raddr_o = page_base + MW'(byte_idx);

  assign buf_we_o    = rd_vld_q && (rd_ph_q == PH_XFER);
  assign buf_waddr_o = rd_idx_q;
  assign buf_wdata_o = mem_rdata_i;
  assign buf_raddr_o = byte_idx;

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign mism_o = mism_q;

endmodule

// File: rtl/page_seq.sv
module page_seq
  import page_seq_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int N_PAGES    = 8,
  parameter int T_ERASE    = 300,
  parameter int T_PROG     = 320,
  parameter int T_XFR      = 280,
  parameter int PW         = $clog2(N_PAGES),
  parameter int BW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [PW-1:0] page_i,
  input  logic          hbuf_we_i,
  input  logic [BW-1:0] hbuf_addr_i,
  input  logic [7:0]    hbuf_wdata_i,
  output logic [7:0]    hbuf_rdata_o,
  input  logic [PW-1:0] hmem_page_i,
  input  logic [BW-1:0] hmem_byte_i,
  output logic [7:0]    hmem_rdata_o,
  output logic [7:0]    status_o,
  output logic          done_o
);

  localparam int MDEPTH = N_PAGES * PAGE_BYTES;
  localparam int MW     = $clog2(MDEPTH);

  logic          busy, mism;
  logic          c_mem_we, c_buf_we;
  logic [MW-1:0] c_mem_waddr, c_mem_raddr;
  logic [7:0]    c_mem_wdata, c_buf_wdata;
  logic [BW-1:0] c_buf_waddr, c_buf_raddr;
  logic [7:0]    mem_q, buf_q;

  logic          b_we;
  logic [BW-1:0] b_waddr, b_raddr;
  logic [7:0]    b_wdata;
  logic [MW-1:0] m_raddr;

  page_seq_ctrl #(
    .PAGE_BYTES(PAGE_BYTES), .N_PAGES(N_PAGES),
    .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_XFR(T_XFR),
    .PW(PW), .BW(BW), .MW(MW)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .start_i(start_i), .op_i(op_e'(op_i)), .page_i(page_i),
    .mem_rdata_i(mem_q), .buf_rdata_i(buf_q),
    .busy_o(busy), .done_o(done_o), .mism_o(mism),
    .mem_we_o(c_mem_we), .mem_waddr_o(c_mem_waddr), .mem_wdata_o(c_mem_wdata),
    .mem_raddr_o(c_mem_raddr),
    .buf_we_o(c_buf_we), .buf_waddr_o(c_buf_waddr), .buf_wdata_o(c_buf_wdata),
    .buf_raddr_o(c_buf_raddr)
  );

  // The sequencer owns both memories while busy; the host only while idle.
  assign b_we    = busy ? c_buf_we    : hbuf_we_i;
  assign b_waddr = busy ? c_buf_waddr : hbuf_addr_i;
  assign b_wdata = busy ? c_buf_wdata : hbuf_wdata_i;
  assign b_raddr = busy ? c_buf_raddr : hbuf_addr_i;
  assign m_raddr = busy ? c_mem_raddr
                        : MW'(hmem_page_i) * MW'(PAGE_BYTES) + MW'(hmem_byte_i);

  page_ram #(.DEPTH(MDEPTH), .WIDTH(8), .AW(MW)) u_main (
    .clk(clk), .we(c_mem_we), .waddr(c_mem_waddr), .wdata(c_mem_wdata),
    .raddr(m_raddr), .rdata(mem_q)
  );

  page_ram #(.DEPTH(PAGE_BYTES), .WIDTH(8), .AW(BW)) u_buf (
    .clk(clk), .we(b_we), .waddr(b_waddr), .wdata(b_wdata),
    .raddr(b_raddr), .rdata(buf_q)
  );

  assign hbuf_rdata_o = buf_q;
  assign hmem_rdata_o = mem_q;

  always_comb begin
    status_o            = 8'h00;
    status_o[STAT_READY] = ~busy;
    status_o[STAT_MISM]  = mism;
  end

endmodule

// File: rtl/page_seq_chk.sv
module page_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic ready,
  input logic mism,
  input logic done_o
);

  // R3: done only when ready is back
  a_r3_done_with_ready: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ready);

  // R3: done is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R3: done follows a busy cycle
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !$past(ready));

  // R2: an accepted start makes the block busy on the next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start_i && ready) |=> !ready);

  // R2: ready comes back only together with done
  a_r2_ready_rise_done: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> done_o);

  // R9: compare flag moves only at the end of an operation
  a_r9_mism_at_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(mism) |-> done_o);

endmodule

bind page_seq page_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i),
  .ready(status_o[7]), .mism(status_o[6]), .done_o(done_o)
);

// File: tb/sim_page_seq.sv
module sim_page_seq;

  localparam int PB = 264;
  localparam int NP = 8;
  localparam int TE = 300;
  localparam int TP = 320;
  localparam int TX = 280;
  localparam int PW = 3;
  localparam int BW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    op = 2'd0;
  logic [PW-1:0] page = '0;
  logic          hwe = 1'b0;
  logic [BW-1:0] haddr = '0;
  logic [7:0]    hwdata = '0;
  logic [7:0]    hbuf_rd, hmem_rd;
  logic [PW-1:0] hpg = '0;
  logic [BW-1:0] hbyte = '0;
  logic [7:0]    status;
  logic          done;

  always #5 clk = ~clk;

  page_seq #(.PAGE_BYTES(PB), .N_PAGES(NP), .T_ERASE(TE), .T_PROG(TP), .T_XFR(TX)) u0 (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .page_i(page),
    .hbuf_we_i(hwe), .hbuf_addr_i(haddr), .hbuf_wdata_i(hwdata), .hbuf_rdata_o(hbuf_rd),
    .hmem_page_i(hpg), .hmem_byte_i(hbyte), .hmem_rdata_o(hmem_rd),
    .status_o(status), .done_o(done)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mbuf [PB];
  logic [7:0] mmem [NP][PB];
  bit         mval [NP];
  bit         mcmp = 1'b0;

  typedef struct packed { logic [1:0] op; logic [2:0] pg; logic [7:0] seed; } vec_t;
  localparam vec_t VECS [6] = '{
    '{2'd0, 3'd2, 8'h11},   // program page 2
    '{2'd0, 3'd5, 8'h3C},   // program page 5
    '{2'd2, 3'd2, 8'h11},   // compare, equal
    '{2'd2, 3'd5, 8'h11},   // compare, different
    '{2'd1, 3'd5, 8'h00},   // transfer page 5
    '{2'd3, 3'd2, 8'h77}    // rewrite page 2
  };

  function automatic logic [7:0] pat(logic [7:0] seed, int i);
    return (seed + 8'(i * 7)) ^ 8'(i >> 3);
  endfunction

  function automatic int dur(logic [1:0] o);
    case (o)
      2'd0:    return TE + TP;
      2'd3:    return TX + TE + TP;
      default: return TX;
    endcase
  endfunction

  function automatic string req_of(logic [1:0] o);
    case (o)
      2'd0:    return "R4";
      2'd1:    return "R5";
      2'd2:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_buf(logic [7:0] seed);
    for (int i = 0; i < PB; i++) begin
      @(negedge clk);
      hwe = 1'b1; haddr = BW'(i); hwdata = pat(seed, i);
      mbuf[i] = pat(seed, i);
    end
    @(negedge clk);
    hwe = 1'b0;
  endtask

  task automatic poke_buf(int i, logic [7:0] v);
    @(negedge clk);
    hwe = 1'b1; haddr = BW'(i); hwdata = v;
    mbuf[i] = v;
    @(negedge clk);
    hwe = 1'b0;
  endtask

  task automatic read_buf(int i, output logic [7:0] d);
    @(negedge clk);
    haddr = BW'(i);
    @(posedge clk);
    @(negedge clk);
    d = hbuf_rd;
  endtask

  task automatic read_mem(int p, int i, output logic [7:0] d);
    @(negedge clk);
    hpg = PW'(p); hbyte = BW'(i);
    @(posedge clk);
    @(negedge clk);
    d = hmem_rd;
  endtask

  task automatic check_buf(string req);
    int bad = -1;
    logic [7:0] a = 8'h00;
    logic [7:0] e = 8'h00;
    for (int i = 0; i < PB; i++) begin
      logic [7:0] d;
      read_buf(i, d);
      if (d !== mbuf[i] && bad < 0) begin bad = i; a = d; e = mbuf[i]; end
    end
    if (bad >= 0) $display("  buffer byte %0d differs", bad);
    check(bad < 0, req, int'(a), int'(e));
  endtask

  task automatic check_page(int p, string req);
    int bad = -1;
    logic [7:0] a = 8'h00;
    logic [7:0] e = 8'h00;
    for (int i = 0; i < PB; i++) begin
      logic [7:0] d;
      read_mem(p, i, d);
      if (d !== mmem[p][i] && bad < 0) begin bad = i; a = d; e = mmem[p][i]; end
    end
    if (bad >= 0) $display("  page %0d byte %0d differs", p, bad);
    check(bad < 0, req, int'(a), int'(e));
  endtask

  // inj: 0 none, 1 extra start (transfer page 5), 2 host buffer write byte 10
  task automatic run_op(logic [1:0] o, int p, int inj, int inj_at,
                        output int n, output bit busy_ok, output bit ready_at_done);
    @(negedge clk);
    start = 1'b1; op = o; page = PW'(p);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0; busy_ok = 1'b1; ready_at_done = 1'b0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) begin ready_at_done = status[7]; break; end
      if (status[7]) busy_ok = 1'b0;
      if (n > 5000) break;
      if (n == inj_at && inj == 1) begin start = 1'b1; op = 2'd1; page = 3'd5; end
      if (n == inj_at && inj == 2) begin hwe = 1'b1; haddr = 9'd10; hwdata = 8'hEE; end
      if (n == inj_at + 1) begin start = 1'b0; hwe = 1'b0; end
    end
  endtask

  task automatic model(logic [1:0] o, int p);
    case (o)
      2'd0: begin for (int i = 0; i < PB; i++) mmem[p][i] = mbuf[i]; mval[p] = 1'b1; end
      2'd2: begin
        mcmp = 1'b0;
        for (int i = 0; i < PB; i++) if (mmem[p][i] !== mbuf[i]) mcmp = 1'b1;
      end
      default: for (int i = 0; i < PB; i++) mbuf[i] = mmem[p][i];
    endcase
  endtask

  task automatic do_op(logic [1:0] o, int p, int inj, int inj_at);
    int n;
    bit bok, rdy;
    string r = req_of(o);
    run_op(o, p, inj, inj_at, n, bok, rdy);
    model(o, p);
    check(n == dur(o), inj == 1 ? "R8 duration" : {r, " R2 duration"}, n, dur(o));
    check(bok, "R2 busy throughout", 0, 1);
    check(rdy, "R3 ready with done", 0, 1);
    @(posedge clk);
    @(negedge clk);
    check(!done, "R3 done single cycle", int'(done), 0);
    check(status[6] == mcmp, o == 2'd2 ? "R6 compare flag" : "R9 flag held",
          int'(status[6]), int'(mcmp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int p = 0; p < NP; p++) mval[p] = 1'b0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(status == 8'h80, "R1 reset status", int'(status), 8'h80);
    check(!done, "R1 reset done", int'(done), 0);

    // Vector table
    foreach (VECS[k]) begin
      load_buf(VECS[k].seed);
      do_op(VECS[k].op, int'(VECS[k].pg), 0, 0);
      check_buf({req_of(VECS[k].op), " buffer"});
      for (int p = 0; p < NP; p++)
        if (mval[p]) check_page(p, {req_of(VECS[k].op), " pages"});
    end

    // R11: one-cycle read latency from page memory
    read_mem(2, 0, d);
    check(d == mmem[2][0], "R11 page read latency", int'(d), int'(mmem[2][0]));
    read_buf(PB - 1, d);
    check(d == mbuf[PB-1], "R11 buffer read latency", int'(d), int'(mbuf[PB-1]));

    // R6: lone differences at last and first byte (buffer equals page 2 now)
    do_op(2'd2, 2, 0, 0);
    check(status[6] == 1'b0, "R6 match clears flag", int'(status[6]), 0);
    poke_buf(PB - 1, mbuf[PB-1] ^ 8'h01);
    do_op(2'd2, 2, 0, 0);
    check(status[6] == 1'b1, "R6 last byte mismatch", int'(status[6]), 1);
    poke_buf(PB - 1, mbuf[PB-1] ^ 8'h01);
    poke_buf(0, mbuf[0] ^ 8'h80);
    do_op(2'd2, 2, 0, 0);
    check(status[6] == 1'b1, "R6 first byte mismatch", int'(status[6]), 1);

    // R9: transfer keeps the set flag
    do_op(2'd1, 2, 0, 0);
    check(status[6] == 1'b1, "R9 flag kept over transfer", int'(status[6]), 1);

    // R8: start during a program is ignored (a transfer would change the buffer)
    load_buf(8'h5D);
    do_op(2'd0, 1, 1, 40);
    check_buf("R8 buffer untouched");
    check_page(1, "R8 program result");

    // R10: host write during a transfer is ignored
    do_op(2'd1, 5, 2, 100);
    read_buf(10, d);
    check(d == mmem[5][10], "R10 write ignored while busy", int'(d), int'(mmem[5][10]));
    check_buf("R10 buffer equals page");

    // R1: reset in the middle of an operation
    @(negedge clk);
    start = 1'b1; op = 2'd0; page = 3'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(status == 8'h80, "R1 status after mid-op reset", int'(status), 8'h80);
    check(!done, "R1 done after mid-op reset", int'(done), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule